// File: doc/BRIEF.md
# Length-Delimited Packet Framer

This block is a byte-stream filter placed at the root of a tree of cut-through routers. Each datagram on its input starts with a length prefix written as an unsigned LEB128 integer. The block reads that prefix and drops it. It then passes on exactly the number of bytes the prefix gives. On the final one of those bytes it raises an end-of-packet flag. The routers after it can return to their idle state when they see that flag, so none of them needs its own byte counter.

Both sides use a valid/ready handshake, and the output also carries a last flag. The block has no input boundary signal. It frames the stream from its own count and nothing else. This lets a second copy sit deeper in the tree and cut an inner datagram out of bytes that arrived across several outer datagrams. The block spends no logic on malformed prefixes. A length larger than the data that actually follows is not detected.

Top module: `eop_framer`

## Requirements
- R1: After synchronous reset, `out_valid` and `out_last` are low and `in_ready` is high.
- R2: Each prefix byte contributes bits 6..0 to the length, with the first byte giving the lowest seven bits. Bit 7 of a byte set to 1 means another prefix byte follows. Prefix bytes never appear on the output.
- R3: After a prefix that decodes to N greater than 0, exactly the next N input bytes appear on the output, in order and unchanged. The byte after them is parsed as a new prefix.
- R4: `out_last` is high on the Nth output byte of a datagram and low on every other output byte.
- R5: A prefix that decodes to zero produces no output bytes. This includes the non-minimal encoding 0x80 0x00. The next input byte is parsed as a new prefix.
- R6: Only the first LEN_GROUPS prefix bytes (4 by default, giving 28 bits) contribute to the length. Later prefix bytes add nothing, but their bit 7 still decides whether the prefix continues.
- R7: While `out_valid` is high and `out_ready` is low, the output holds: `out_valid`, `out_data` and `out_last` keep their values into the next cycle.
- R8: While the block is reading a prefix, `in_ready` is high whatever the state of `out_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte is the final byte of the datagram |

## Verification
The block's state is a prefix accumulator, a group index and a down-counter. A fault in any of them shows at the ports within a single datagram, in one of three ways: a prefix byte shows up on the output, `out_last` lands one byte early or late, or the stream loses alignment so that every later datagram is framed wrongly. The bench sweeps every single-byte length, runs multi-byte and over-long prefixes, and drives random stalls on both sides. Because it compares every output byte against a model, a wrong count is caught at the first misframed byte rather than at the end of the run.

// File: rtl/eopf_pkg.sv
package eopf_pkg;
  localparam int BYTE_W  = 8;
  localparam int GROUP_W = 7;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/eopf_len_decoder.sv
module eopf_len_decoder
  import eopf_pkg::*;
#(
  parameter int GROUPS = 4,
  parameter int CNT_W  = GROUPS * GROUP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  byte_t            din,
  output logic             done,
  output logic [CNT_W-1:0] value
);
  localparam int GRP_W = $clog2(GROUPS + 1);

  logic [CNT_W-1:0] acc;
  logic [GRP_W-1:0] grp;

  always_comb begin
    value = acc;
    for (int g = 0; g < GROUPS; g++) begin
      if (grp == GRP_W'(g)) value[g*GROUP_W +: GROUP_W] = din[GROUP_W-1:0];
    end
  end

  assign done = take && !din[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      grp <= '0;
    end else if (take) begin
      if (!din[BYTE_W-1]) begin
        acc <= '0;
        grp <= '0;
      end else begin
        acc <= value;
        if (grp != GRP_W'(GROUPS)) grp <= grp + GRP_W'(1);
      end
    end
  end

  // R2
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (grp == '0) && (acc == '0));

  // R6
  group_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (take && din[BYTE_W-1] && grp == GRP_W'(GROUPS)) |=> $stable(acc));
endmodule

// File: rtl/eopf_countdown.sv
module eopf_countdown #(
  parameter int CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             active,
  output logic             final_beat
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - CNT_W'(1);
  end

  assign active     = cnt != '0;
  assign final_beat = cnt == CNT_W'(1);

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    dec |-> active);

  // R3
  load_starts_chk: assert property (@(posedge clk) disable iff (rst)
    (load && load_val != '0) |=> active);

  // R4
  ends_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (dec && final_beat && !load) |=> !active);
endmodule

// File: rtl/eopf_out_stage.sv
module eopf_out_stage
  import eopf_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  push,
  input  byte_t din,
  input  logic  last_in,
  input  logic  out_ready,
  output logic  can_push,
  output logic  out_valid,
  output byte_t out_data,
  output logic  out_last
);
  assign can_push = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (push) begin
      out_valid <= 1'b1;
      out_data  <= din;
      out_last  <= last_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last));

  // R4
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
endmodule

// File: rtl/eop_framer.sv
module eop_framer
  import eopf_pkg::*;
#(
  parameter int LEN_GROUPS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last
);
  localparam int CNT_W = LEN_GROUPS * GROUP_W;

  logic             active, final_beat, can_push;
  logic             take_len, take_body, len_done, load;
  logic [CNT_W-1:0] len_value;

  assign in_ready  = active ? can_push : 1'b1;
  assign take_len  = in_valid && in_ready && !active;
  assign take_body = in_valid && in_ready && active;
  assign load      = len_done && (len_value != '0);

  eopf_len_decoder #(.GROUPS(LEN_GROUPS), .CNT_W(CNT_W)) u_dec (
    .clk   (clk),
    .rst   (rst),
    .take  (take_len),
    .din   (in_data),
    .done  (len_done),
    .value (len_value)
  );

  eopf_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .load_val   (len_value),
    .dec        (take_body),
    .active     (active),
    .final_beat (final_beat)
  );

  eopf_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .push      (take_body),
    .din       (in_data),
    .last_in   (final_beat),
    .out_ready (out_ready),
    .can_push  (can_push),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last)
  );

  // R5
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (len_done && len_value == '0) |=> !active);

  // R2
  prefix_not_forwarded_chk: assert property (@(posedge clk) disable iff (rst)
    take_len |=> !out_valid || $stable(out_data));
endmodule

// File: tb/sim_eop_framer.sv
module sim_eop_framer;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 150000;

  typedef struct {
    logic [7:0] d;
    logic       l;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       out_last;

  logic [7:0] in_q[$];
  bit         in_is_len[$];
  exp_t       exp_q[$];
  int         checks = 0;
  int         errors = 0;
  int         cycles = 0;
  bit         prev_stall = 0;
  logic [7:0] prev_d;
  logic       prev_l;

  eop_framer u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic push_len_byte(logic [7:0] b);
    in_q.push_back(b);
    in_is_len.push_back(1'b1);
  endtask

  task automatic push_body(int n, string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      logic [7:0] b = 8'($urandom);
      in_q.push_back(b);
      in_is_len.push_back(1'b0);
      e.d = b;
      e.l = (i == n - 1);
      e.tag = (i == n - 1) ? "R4" : tag;
      exp_q.push_back(e);
    end
  endtask

  // R2: seven-bit groups, lowest first, bit 7 = more bytes follow
  task automatic add_dgram(int n, string tag);
    int v = n;
    do begin
      logic [7:0] b = {1'b0, 7'(v)};
      v = v >> 7;
      if (v != 0) b[7] = 1'b1;
      push_len_byte(b);
    end while (v != 0);
    push_body(n, tag);
  endtask

  task automatic run(int rdy_pct, int vld_pct);
    while ((in_q.size() != 0 || exp_q.size() != 0) && cycles < LIMIT) begin
      @(negedge clk);
      cycles++;
      if (prev_stall)
        chk(out_valid && out_data == prev_d && out_last == prev_l,
            "R7", "output held under stall", int'(out_data), int'(prev_d));
      out_ready = (($urandom % 100) < rdy_pct);
      in_valid  = (in_q.size() != 0) && (($urandom % 100) < vld_pct);
      in_data   = in_valid ? in_q[0] : 8'h00;
      #1;
      if (in_valid && in_is_len[0])
        chk(in_ready == 1'b1, "R8", "in_ready during prefix", int'(in_ready), 1);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected output byte", int'(out_data), -1);
        end else begin
          exp_t e = exp_q.pop_front();
          chk(out_data == e.d, e.tag, "data", int'(out_data), int'(e.d));
          chk(out_last == e.l, e.tag, "last flag", int'(out_last), int'(e.l));
        end
      end
      if (in_valid && in_ready) begin
        void'(in_q.pop_front());
        void'(in_is_len.pop_front());
      end
      prev_stall = out_valid && !out_ready;
      prev_d = out_data;
      prev_l = out_last;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(out_last == 1'b0, "R1", "out_last after reset", int'(out_last), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // R3, R4: smallest datagram, then back to back
    add_dgram(1, "R3");
    add_dgram(3, "R3");
    run(100, 100);

    // R5: zero length, minimal and non-minimal, then a real datagram
    push_len_byte(8'h00);
    push_len_byte(8'h80);
    push_len_byte(8'h00);
    add_dgram(2, "R5");
    run(70, 80);

    // R2: two- and three-byte prefixes (130, 16389)
    add_dgram(130, "R2");
    add_dgram(16389, "R2");
    run(90, 90);

    // R6: five prefix bytes, fifth ignored: 0x83 0x80 0x80 0x80 0x7F -> 3
    push_len_byte(8'h83);
    push_len_byte(8'h80);
    push_len_byte(8'h80);
    push_len_byte(8'h80);
    push_len_byte(8'h7F);
    push_body(3, "R6");
    add_dgram(4, "R6");
    run(60, 100);

    // R3, R7: sweep every single-byte length under several stall mixes
    for (int p = 0; p < 3; p++) begin
      for (int n = 0; n < 128; n++) add_dgram(n, "R3");
      run((p == 0) ? 100 : (p == 1) ? 50 : 25, (p == 2) ? 100 : 60);
    end

    // R2, R7: random lengths with random stalls on both sides
    for (int k = 0; k < 40; k++) add_dgram(int'($urandom % 600), "R2");
    run(55, 65);

    if (cycles >= LIMIT) chk(1'b0, "R3", "watchdog expired", cycles, LIMIT);
    chk(exp_q.size() == 0, "R3", "outstanding expected bytes", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule